// File: doc/BRIEF.md
# Ethernet Destination Hash Filter

This block is the address-filter stage of an Ethernet receive path. It watches the first bytes of each incoming frame, gathers the 48-bit destination address, and reduces that address to a 6-bit index. The index is an exclusive-or across the address, one column per index bit, with the columns taken six bits apart. A 64-bit hash table selects one bit with that index. Software loads the table as two 32-bit halves through a simple write port.

One clock after the sixth address byte is taken in, the block issues a single-cycle decision. The decision says whether to keep the frame and gives a code for the rule that matched. The rules, from highest priority down, are: the all-ones broadcast address, an exact match against the programmed station address, a hash hit gated by the address's group bit, and copy-all. A receive controller samples the decision to keep or drop the frame that is arriving.

Top module: `dest_hash_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are low and all 64 hash bits are zero, so with both hash enables set and copy-all clear a frame that is neither broadcast nor the station address is rejected.
- R2: Hash index bit n (n = 0..5) is the XOR of destination bits n, n+6, n+12, ..., n+42. Destination bit 8*i+j is bit j of received address byte i, so bit 0 is the LSB of the first byte.
- R3: A write with `hash_sel` = 0 loads table bits 0..31 from `hash_wdata[31:0]`. A write with `hash_sel` = 1 loads bits 32..63. Table bit k is the bit that index value k selects.
- R4: When the group bit (destination bit 0) is 1, the indexed table bit is 1 and `cfg_multi_hash_en` is set, the frame is accepted with code 4 (hash-multicast). With `cfg_multi_hash_en` clear, this rule never matches.
- R5: When the group bit is 0, the indexed table bit is 1 and `cfg_uni_hash_en` is set, the frame is accepted with code 3 (hash-unicast). With `cfg_uni_hash_en` clear, this rule never matches.
- R6: A destination equal to {`sta_hi`, `sta_lo`} is accepted with code 1 (station). `sta_lo[7:0]` is the first byte received and `sta_hi[15:8]` is the sixth. An address that differs in any one bit does not match.
- R7: The all-ones destination gives code 2 (broadcast, accepted) when `cfg_no_bcast` is 0. When `cfg_no_bcast` is 1 it gives code 0 (rejected). This holds whatever the station, hash and copy-all settings are.
- R8: With `cfg_copy_all` set, a non-broadcast frame that no other rule matches is accepted with code 5 (promiscuous).
- R9: The rules are checked in this order: broadcast, station, hash, copy-all. A frame that several rules match reports the code of the highest one.
- R10: `dec_valid` is high for exactly one cycle, the cycle after the clock edge that takes in the sixth address byte. Bytes after the sixth produce no further decision until the next start of frame.
- R11: A byte with `rx_sof` set restarts address collection at byte 0, even part-way through an address. Bytes arriving before any start of frame are ignored.
- R12: When `dec_valid` is high, `dec_accept` is 1 exactly when `dec_kind` is not 0. The codes are: 0 none, 1 station, 2 broadcast, 3 hash-unicast, 4 hash-multicast, 5 promiscuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_data | input | 8 | Received byte |
| hash_we | input | 1 | Write one half of the hash table |
| hash_sel | input | 1 | Half to write: 0 low (bits 0..31), 1 high (bits 32..63) |
| hash_wdata | input | 32 | Data for the selected half |
| sta_lo | input | 32 | Station address, bytes 0 to 3 (byte 0 in bits 7:0) |
| sta_hi | input | 16 | Station address, bytes 4 and 5 (byte 4 in bits 7:0) |
| cfg_copy_all | input | 1 | Accept every frame that no other rule matches |
| cfg_no_bcast | input | 1 | Reject the all-ones destination |
| cfg_uni_hash_en | input | 1 | Allow hash hits on unicast addresses |
| cfg_multi_hash_en | input | 1 | Allow hash hits on multicast addresses |
| dec_valid | output | 1 | One-cycle strobe: decision outputs are valid |
| dec_accept | output | 1 | Keep the frame |
| dec_kind | output | 3 | Matching rule code, see R12 |

## Verification
The checker tests on every cycle that the decision strobe lasts one cycle and follows the completed address by exactly one cycle. It also tests that a broadcast, hash-unicast, hash-multicast or promiscuous code is never reported while the matching option is disabled. The actual index fold, the split of the table into two halves, the exact station compare and the priority among rules can only be shown by the bench's scenarios. Those scenarios sweep every one of the 64 index values with both group-bit values, once against a table holding only that bit and once against a table holding every other bit. They also cover the enable gating, the broadcast and station corners, restarts and trailing bytes.

// File: rtl/dhf_pkg.sv
`timescale 1ns/1ps
package dhf_pkg;

    // Decision codes reported on dec_kind
    typedef enum logic [2:0] {
        MK_NONE       = 3'd0,
        MK_STATION    = 3'd1,
        MK_BCAST      = 3'd2,
        MK_HASH_UNI   = 3'd3,
        MK_HASH_MULTI = 3'd4,
        MK_PROMISC    = 3'd5
    } match_kind_e;

endpackage

// File: rtl/dhf_addr_collector.sv
`timescale 1ns/1ps
// Gathers the first ADDR_BYTES bytes of a frame into one address word.
module dhf_addr_collector #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid,
    input  logic                    byte_sof,
    input  logic [7:0]              byte_data,
    output logic [ADDR_BYTES*8-1:0] addr_o,
    output logic                    done_o
);
    localparam int ADDR_W = ADDR_BYTES * 8;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;   // 0: no frame open, CNT_FULL: address complete
        logic [ADDR_W-1:0] addr;
        logic              done;
    } coll_t;

    coll_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (byte_valid) begin
            if (byte_sof) begin
                st_d.addr[7:0] = byte_data;
                st_d.cnt       = CNT_ONE;
                st_d.done      = (CNT_ONE == CNT_FULL);
            end else if (st_q.cnt != '0 && st_q.cnt != CNT_FULL) begin
                st_d.addr[int'(st_q.cnt)*8 +: 8] = byte_data;
                st_d.cnt  = st_q.cnt + CNT_ONE;
                st_d.done = ((st_q.cnt + CNT_ONE) == CNT_FULL);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign done_o = st_q.done;

endmodule

// File: rtl/dhf_hash_fold.sv
`timescale 1ns/1ps
// Reduces an address to an index: index bit n is the XOR of every IDX_W-th bit from n.
module dhf_hash_fold #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int TERMS = (ADDR_W + IDX_W - 1) / IDX_W;

    for (genvar n = 0; n < IDX_W; n++) begin : g_col
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int k = 0; k < TERMS; k++) begin
                if (n + k * IDX_W < ADDR_W) begin
                    acc = acc ^ addr_i[n + k * IDX_W];
                end
            end
        end
        assign idx_o[n] = acc;
    end

endmodule

// File: rtl/dhf_hash_table.sv
`timescale 1ns/1ps
// Hash table loaded one word at a time, read one bit at a time.
module dhf_hash_table #(
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en,
    input  logic [$clog2((1 << IDX_W) / WORD_W)-1:0]     wr_sel,
    input  logic [WORD_W-1:0]                            wr_data,
    input  logic [IDX_W-1:0]                             idx_i,
    output logic                                         hit_o
);
    localparam int TABLE_W = 1 << IDX_W;

    logic [TABLE_W-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[int'(wr_sel)*WORD_W +: WORD_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign hit_o = tbl_q[idx_i];

endmodule

// File: rtl/dest_hash_filter.sv
`timescale 1ns/1ps
// Destination address filter: broadcast, station, hash and copy-all rules.
module dest_hash_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 6,
    parameter int WORD_W     = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rx_valid,
    input  logic                              rx_sof,
    input  logic [7:0]                        rx_data,
    input  logic                              hash_we,
    input  logic [$clog2((1 << IDX_W) / WORD_W)-1:0] hash_sel,
    input  logic [WORD_W-1:0]                 hash_wdata,
    input  logic [WORD_W-1:0]                 sta_lo,
    input  logic [ADDR_BYTES*8-WORD_W-1:0]    sta_hi,
    input  logic                              cfg_copy_all,
    input  logic                              cfg_no_bcast,
    input  logic                              cfg_uni_hash_en,
    input  logic                              cfg_multi_hash_en,
    output logic                              dec_valid,
    output logic                              dec_accept,
    output logic [2:0]                        dec_kind
);
    import dhf_pkg::*;

    localparam int ADDR_W = ADDR_BYTES * 8;

    typedef struct packed {
        logic        valid;
        logic        accept;
        match_kind_e kind;
    } dec_t;

    logic [ADDR_W-1:0] addr;
    logic              addr_done;
    logic [IDX_W-1:0]  hash_idx;
    logic              hash_hit;
    logic              is_bcast;
    logic              sta_hit;
    logic              grp_bit;

    dec_t dec_d, dec_q;

    dhf_addr_collector #(
        .ADDR_BYTES (ADDR_BYTES)
    ) collect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (rx_valid),
        .byte_sof   (rx_sof),
        .byte_data  (rx_data),
        .addr_o     (addr),
        .done_o     (addr_done)
    );

    dhf_hash_fold #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) fold_i (
        .addr_i (addr),
        .idx_o  (hash_idx)
    );

    dhf_hash_table #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hash_we),
        .wr_sel  (hash_sel),
        .wr_data (hash_wdata),
        .idx_i   (hash_idx),
        .hit_o   (hash_hit)
    );

    assign is_bcast = &addr;
    assign sta_hit  = (addr == {sta_hi, sta_lo});
    assign grp_bit  = addr[0];

    always_comb begin
        dec_d        = '0;
        dec_d.kind   = MK_NONE;
        dec_d.valid  = addr_done;
        if (addr_done) begin
            if (is_bcast) begin
                dec_d.kind = cfg_no_bcast ? MK_NONE : MK_BCAST;
            end else if (sta_hit) begin
                dec_d.kind = MK_STATION;
            end else if (hash_hit && grp_bit && cfg_multi_hash_en) begin
                dec_d.kind = MK_HASH_MULTI;
            end else if (hash_hit && !grp_bit && cfg_uni_hash_en) begin
                dec_d.kind = MK_HASH_UNI;
            end else if (cfg_copy_all) begin
                dec_d.kind = MK_PROMISC;
            end
            dec_d.accept = (dec_d.kind != MK_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '{valid: 1'b0, accept: 1'b0, kind: MK_NONE};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign dec_kind   = dec_q.kind;

endmodule

// File: rtl/dhf_checker.sv
`timescale 1ns/1ps
module dhf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_done,
    input logic       cfg_copy_all,
    input logic       cfg_no_bcast,
    input logic       cfg_uni_hash_en,
    input logic       cfg_multi_hash_en,
    input logic       dec_valid,
    input logic [2:0] dec_kind
);
    import dhf_pkg::*;

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid); // R10

    AST_DONE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |=> dec_valid); // R10

    AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 3'(MK_BCAST)) |-> !$past(cfg_no_bcast)); // R7

    AST_MULTI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 3'(MK_HASH_MULTI)) |-> $past(cfg_multi_hash_en)); // R4

    AST_UNI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 3'(MK_HASH_UNI)) |-> $past(cfg_uni_hash_en)); // R5

    AST_PROMISC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 3'(MK_PROMISC)) |-> $past(cfg_copy_all)); // R8

endmodule

bind dest_hash_filter dhf_checker chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .addr_done         (addr_done),
    .cfg_copy_all      (cfg_copy_all),
    .cfg_no_bcast      (cfg_no_bcast),
    .cfg_uni_hash_en   (cfg_uni_hash_en),
    .cfg_multi_hash_en (cfg_multi_hash_en),
    .dec_valid         (dec_valid),
    .dec_kind          (dec_kind)
);

// File: tb/dest_hash_filter_tb_top.sv
`timescale 1ns/1ps
module dest_hash_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof;
    logic [7:0]  rx_data;
    logic        hash_we;
    logic [0:0]  hash_sel;
    logic [31:0] hash_wdata;
    logic [31:0] sta_lo;
    logic [15:0] sta_hi;
    logic        cfg_copy_all, cfg_no_bcast, cfg_uni_hash_en, cfg_multi_hash_en;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_kind;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] tbl_m;

    always #2.5 clk = ~clk;

    dest_hash_filter dut_i (
        .clk (clk), .rst_n (rst_n),
        .rx_valid (rx_valid), .rx_sof (rx_sof), .rx_data (rx_data),
        .hash_we (hash_we), .hash_sel (hash_sel), .hash_wdata (hash_wdata),
        .sta_lo (sta_lo), .sta_hi (sta_hi),
        .cfg_copy_all (cfg_copy_all), .cfg_no_bcast (cfg_no_bcast),
        .cfg_uni_hash_en (cfg_uni_hash_en), .cfg_multi_hash_en (cfg_multi_hash_en),
        .dec_valid (dec_valid), .dec_accept (dec_accept), .dec_kind (dec_kind)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Index computed arithmetically: bit b of the address lands in column b mod 6
    function automatic logic [5:0] fold(input logic [47:0] a);
        logic [5:0] r = '0;
        for (int b = 0; b < 48; b++) r[b % 6] = r[b % 6] ^ a[b];
        return r;
    endfunction

    function automatic logic [2:0] model(input logic [47:0] a);
        logic hit = tbl_m[fold(a)];
        if (a == '1) return cfg_no_bcast ? 3'd0 : 3'd2;
        if (a == {sta_hi, sta_lo}) return 3'd1;
        if (hit && a[0] && cfg_multi_hash_en) return 3'd4;
        if (hit && !a[0] && cfg_uni_hash_en) return 3'd3;
        if (cfg_copy_all) return 3'd5;
        return 3'd0;
    endfunction

    task automatic load_table(input logic [63:0] t);
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            hash_we    = 1'b1;
            hash_sel   = 1'(s);
            hash_wdata = t[s*32 +: 32];
        end
        @(negedge clk);
        hash_we = 1'b0;
        tbl_m   = t;
    endtask

    // pre: junk bytes before the address (first one carries sof); extra: trailing bytes
    task automatic send_frame(input logic [47:0] a, input int pre, input int extra,
                              input string req);
        logic [2:0] exp = model(a);
        int total = pre + 6 + extra;
        for (int c = 0; c < total + 4; c++) begin
            @(negedge clk);
            if (c > 0) begin
                chk(dec_valid == (c == pre + 7), "R10", "dec_valid timing",
                    64'(dec_valid), 64'(c == pre + 7));
                if (c == pre + 7) begin
                    chk(dec_kind == exp, req, "dec_kind", 64'(dec_kind), 64'(exp));
                    chk(dec_accept == (exp != 3'd0), "R12", "dec_accept",
                        64'(dec_accept), 64'(exp != 3'd0));
                end
            end
            if (c < total) begin
                rx_valid = 1'b1;
                rx_sof   = (c == 0) || (c == pre);
                if (c >= pre && c < pre + 6) rx_data = a[(c - pre)*8 +: 8];
                else rx_data = 8'(8'hA7 + c * 13);
            end else begin
                rx_valid = 1'b0;
                rx_sof   = 1'b0;
            end
        end
    endtask

    function automatic logic [47:0] addr_for(input int t, input bit g);
        logic [47:0] a = {24'hC3A51F ^ 24'(t * 977), 24'h7E8D40};
        a[5:0] = 6'(t) ^ fold({a[47:6], 6'b0});
        if (a[0] != g) begin
            a[0] = ~a[0];
            a[6] = ~a[6];
        end
        return a;
    endfunction

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        rx_valid = 0; rx_sof = 0; rx_data = 0;
        hash_we = 0; hash_sel = 0; hash_wdata = 0;
        sta_lo = 32'h9ABC_DEF0; sta_hi = 16'h1234;
        cfg_copy_all = 0; cfg_no_bcast = 0; cfg_uni_hash_en = 1; cfg_multi_hash_en = 1;
        tbl_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dec_valid && !dec_accept, "R1", "reset outputs", 64'({dec_valid, dec_accept}), 64'd0);

        // R1: table empty after reset, so no hash hit for either group value
        send_frame(48'h0000_0000_0001, 0, 0, "R1");
        send_frame(48'h5555_0000_00F2, 0, 0, "R1");

        // R2/R3/R4/R5: every index, both group values, hit and miss tables
        for (int t = 0; t < 64; t++) begin
            for (int g = 0; g < 2; g++) begin
                load_table(64'd1 << t);
                send_frame(addr_for(t, 1'(g)), 0, 0, g ? "R4" : "R5");
                load_table(~(64'd1 << t));
                send_frame(addr_for(t, 1'(g)), 0, 0, "R3");
            end
        end

        // R4/R5 gating with a full table
        load_table('1);
        cfg_uni_hash_en = 0; cfg_multi_hash_en = 1;
        send_frame(addr_for(17, 1'b0), 0, 0, "R5");
        send_frame(addr_for(40, 1'b1), 0, 0, "R4");
        cfg_uni_hash_en = 1; cfg_multi_hash_en = 0;
        send_frame(addr_for(17, 1'b0), 0, 0, "R5");
        send_frame(addr_for(40, 1'b1), 0, 0, "R4");

        // R6: station match and one-bit miss
        cfg_uni_hash_en = 0; cfg_multi_hash_en = 0;
        sta_lo = 32'h0A0B_0C0D; sta_hi = 16'h0E0F;
        send_frame(48'h0E0F_0A0B_0C0D, 0, 0, "R6");
        send_frame(48'h0E0F_0A0B_0C0D ^ 48'h0100_0000_0000, 0, 0, "R6");
        send_frame(48'h0E0F_0A0B_0C0C, 0, 0, "R6");

        // R7: broadcast with and without rejection, other rules all on
        cfg_copy_all = 1; cfg_uni_hash_en = 1; cfg_multi_hash_en = 1;
        send_frame('1, 0, 0, "R7");
        cfg_no_bcast = 1;
        send_frame('1, 0, 0, "R7");
        sta_lo = '1; sta_hi = '1;
        send_frame('1, 0, 0, "R7");
        cfg_no_bcast = 0;
        send_frame('1, 0, 0, "R9");

        // R8: copy-all on non-matching frames
        sta_lo = 32'h0A0B_0C0D; sta_hi = 16'h0E0F;
        load_table('0);
        send_frame(48'h3141_5926_5358, 0, 0, "R8");
        send_frame(48'h2718_2818_2845, 0, 0, "R8");
        cfg_copy_all = 0;
        send_frame(48'h3141_5926_5358, 0, 0, "R8");

        // R9: station beats hash and copy-all; hash beats copy-all
        load_table('1);
        cfg_copy_all = 1;
        send_frame(48'h0E0F_0A0B_0C0D, 0, 0, "R9");
        send_frame(addr_for(5, 1'b0), 0, 0, "R9");
        send_frame(addr_for(60, 1'b1), 0, 0, "R9");

        // R10: trailing bytes give no second decision
        cfg_copy_all = 0;
        send_frame(addr_for(33, 1'b1), 0, 9, "R10");
        // R11: restart part-way through an address
        load_table(64'd1 << 22);
        send_frame(addr_for(22, 1'b0), 3, 2, "R11");
        send_frame(addr_for(22, 1'b1), 5, 0, "R11");

        // R11: bytes without any start of frame are ignored
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            chk(!dec_valid, "R11", "no decision without sof", 64'(dec_valid), 64'd0);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'(c);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!dec_valid, "R11", "no decision without sof", 64'(dec_valid), 64'd0);

        summary();
    end

endmodule